// File: doc/BRIEF.md
# Dual-Clock Display Scan Buffer

This block carries display data across an asynchronous boundary. On the memory side it asks an external arbiter for bursts of 64-bit words with a request/grant handshake, and it stores the words in a small register array. On the video side it hands the same words out in one of two shapes: a narrow stream of one byte per read for the legacy attribute path, or a wide stream of four 24-bit pixels per read for a direct pixel path to a DAC.

The refill policy is set by configuration inputs. Four fetch classes (byte addressing, word addressing, double-word addressing and text font fetches) each have their own burst length and refill watermark, and a class input selects which pair is in force. A refill is asked for when the buffer, as seen from the memory side, is below the watermark and the burst still fits. The buffer then waits for that burst to finish before it asks again.

Pointers cross the boundary in Gray code through two-flop synchronizers. A read that finds too little data raises an underflow pulse and leaves the outputs unchanged.

Top module: `svb_top`

## Requirements
- R1: In the write domain the fill level is the write position minus the read position rounded down to an even word. From idle, `mem_req` rises one `wclk` cycle after the level is below the selected class's watermark, the selected burst length is nonzero and level plus burst length is at most DEPTH. `mem_burst` holds the burst length latched when the request rose. Class codes: 0 byte, 1 word, 2 double word, 3 font. Class c's fields are `cfg_burst[c*BLW +: BLW]` and `cfg_wmark[c*(AW+1) +: AW+1]`.
- R2: Once raised, `mem_req` stays high until a cycle with `mem_gnt` high, and falls at the next edge. No new request is raised until `mem_burst` words have been accepted.
- R3: A word on `mem_wr_data` is stored only in a cycle with `mem_wr_valid` high during a granted burst. Valid cycles outside a burst are ignored, and the buffer never holds more than DEPTH words.
- R4: With `wide` low, each `rd_en` cycle with at least one word stored puts the next byte on `pix8` at the next `rclk` edge. Bytes come least-significant first, and the word is retired after its eighth byte.
- R5: With `wide` high, each `rd_en` cycle with at least two words stored retires two words A then B. The next `rclk` edge gives `pix96` = {B[55:32], B[23:0], A[55:32], A[23:0]}, so pixel 0 is in bits 23:0.
- R6: A read with fewer words stored than it needs (1 narrow, 2 wide) sets `underflow` high for one cycle. It leaves `pix8`, `pix96` and the read position unchanged.
- R7: Words come out in the order they were written. Pointers cross domains in Gray code and change by at most one bit per cycle.
- R8: While reset is held, `mem_req` and `underflow` are low and `pix8` and `pix96` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Memory-side clock |
| wrst_n | input | 1 | Memory-side asynchronous reset, active low |
| cls | input | 2 | Selected fetch class |
| cfg_burst | input | 4*BLW | Burst length per class |
| cfg_wmark | input | 4*(AW+1) | Refill watermark per class |
| mem_req | output | 1 | Burst request to the arbiter |
| mem_burst | output | BLW | Length of the requested burst in words |
| mem_gnt | input | 1 | Grant from the arbiter |
| mem_wr_valid | input | 1 | Data word valid |
| mem_wr_data | input | 64 | Data word from memory |
| rclk | input | 1 | Video clock |
| rrst_n | input | 1 | Video-side asynchronous reset, active low |
| rd_en | input | 1 | Read one output unit |
| wide | input | 1 | 1: four-pixel output, 0: byte output |
| pix8 | output | 8 | Narrow pixel stream |
| pix96 | output | 96 | Four 24-bit pixels |
| underflow | output | 1 | Read found too little data |

## Verification
A corrupted write pointer or a bad crossing shows on the video side within the synchronizer delay plus one read. A lost, repeated or stray word is caught by the next byte or pixel compared against the stream the bench wrote. A wrong level count on the memory side shows within a cycle as a request that rises past the watermark, fails to rise, or appears during a burst. Draining to empty then proves no extra word was stored, because the first read past the known count must underflow.

// File: rtl/svb_pkg.sv
package svb_pkg;
  localparam int WORD_W = 64;
  localparam int BYTE_W = 8;
  localparam int PIX_W  = 24;
  localparam int NCLS   = 4;

  typedef enum logic [1:0] {
    F_IDLE = 2'd0,
    F_REQ  = 2'd1,
    F_XFER = 2'd2
  } fill_st_e;
endpackage

// File: rtl/svb_gray_ptr.sv
module svb_gray_ptr #(
  parameter int W     = 5,
  parameter bit PAIRS = 1'b0,
  localparam int GW   = PAIRS ? W - 1 : W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    step,
  output logic [W-1:0]  bin,
  output logic [GW-1:0] gray
);
  function automatic logic [GW-1:0] bin2gray(input logic [GW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [W-1:0] nxt;
  assign nxt = bin + W'(step);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bin <= '0;
    else        bin <= nxt;

  generate
    if (PAIRS) begin : g_pair
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) gray <= '0;
        else        gray <= bin2gray(nxt[W-1:1]);
    end else begin : g_full
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) gray <= '0;
        else        gray <= bin2gray(nxt);
    end
  endgenerate
endmodule

// File: rtl/svb_ptr_sync.sv
module svb_ptr_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  function automatic logic [W-1:0] gray2bin(input logic [W-1:0] g);
    logic [W-1:0] b;
    b[W-1] = g[W-1];
    for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0] s1, s2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= gray_in;
      s2 <= s1;
    end

  assign bin_out = gray2bin(s2);
endmodule

// File: rtl/svb_fill.sv
module svb_fill
  import svb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int BLW   = 5,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cls,
  input  logic [NCLS*BLW-1:0] cfg_burst,
  input  logic [NCLS*PW-1:0]  cfg_wmark,
  input  logic                mem_gnt,
  input  logic                mem_wr_valid,
  input  logic [PW-1:0]       wptr,
  input  logic [PW-1:0]       rptr_safe,
  output logic                mem_req,
  output logic [BLW-1:0]      mem_burst,
  output logic                wr_en,
  output logic                busy,
  output logic [PW-1:0]       level
);
  function automatic logic room_for(input logic [PW-1:0] lvl, input logic [BLW-1:0] n);
    return (int'(lvl) + int'(n)) <= DEPTH;
  endfunction

  fill_st_e       st;
  logic [BLW-1:0] remain, burst_q, burst_sel;
  logic [PW-1:0]  wm_sel;
  logic           want;

  assign burst_sel = cfg_burst[cls*BLW +: BLW];
  assign wm_sel    = cfg_wmark[cls*PW +: PW];
  assign level     = wptr - rptr_safe;
  assign want      = (level < wm_sel) && room_for(level, burst_sel) && (burst_sel != '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= F_IDLE;
      remain  <= '0;
      burst_q <= '0;
    end else begin
      case (st)
        F_IDLE: if (want) begin
          st      <= F_REQ;
          burst_q <= burst_sel;
        end
        F_REQ: if (mem_gnt) begin
          st     <= F_XFER;
          remain <= burst_q;
        end
        F_XFER: if (wr_en) begin
          remain <= remain - BLW'(1);
          if (remain == BLW'(1)) st <= F_IDLE;
        end
        default: st <= F_IDLE;
      endcase
    end

  assign mem_req   = (st == F_REQ);
  assign busy      = (st == F_XFER);
  assign wr_en     = busy && mem_wr_valid;
  assign mem_burst = burst_q;
endmodule

// File: rtl/svb_drain.sv
module svb_drain
  import svb_pkg::*;
#(
  parameter int PW = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_en,
  input  logic                 wide,
  input  logic [PW-1:0]        wptr,
  input  logic [PW-1:0]        rptr,
  input  logic [WORD_W-1:0]    lo,
  input  logic [2*PIX_W-1:0]   hi,
  output logic [1:0]           step,
  output logic [BYTE_W-1:0]    pix8,
  output logic [4*PIX_W-1:0]   pix96,
  output logic                 underflow
);
  function automatic logic [4*PIX_W-1:0] pack4(input logic [WORD_W-1:0] a,
                                               input logic [2*PIX_W-1:0] b);
    return {b, a[55:32], a[23:0]};
  endfunction

  logic [PW-1:0] level;
  logic [2:0]    idx;
  logic          ok;

  assign level = wptr - rptr;

  always_comb begin
    ok   = wide ? (level >= PW'(2)) : (level != '0);
    step = 2'd0;
    if (rd_en && ok) step = wide ? 2'd2 : ((idx == 3'd7) ? 2'd1 : 2'd0);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      idx       <= '0;
      pix8      <= '0;
      pix96     <= '0;
      underflow <= 1'b0;
    end else if (rd_en && !ok) begin
      underflow <= 1'b1;
    end else begin
      underflow <= 1'b0;
      if (rd_en && wide) begin
        pix96 <= pack4(lo, hi);
        idx   <= '0;
      end else if (rd_en) begin
        pix8 <= lo[{idx, 3'b000} +: BYTE_W];
        idx  <= idx + 3'd1;
      end
    end
endmodule

// File: rtl/svb_top.sv
module svb_top
  import svb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int BLW   = 5,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic                 wclk,
  input  logic                 wrst_n,
  input  logic [1:0]           cls,
  input  logic [4*BLW-1:0]     cfg_burst,
  input  logic [4*PW-1:0]      cfg_wmark,
  output logic                 mem_req,
  output logic [BLW-1:0]       mem_burst,
  input  logic                 mem_gnt,
  input  logic                 mem_wr_valid,
  input  logic [63:0]          mem_wr_data,
  input  logic                 rclk,
  input  logic                 rrst_n,
  input  logic                 rd_en,
  input  logic                 wide,
  output logic [7:0]           pix8,
  output logic [95:0]          pix96,
  output logic                 underflow
);
  logic [WORD_W-1:0] mem [DEPTH];

  logic              wr_en, busy;
  logic [PW-1:0]     wr_level, wptr_bin, wptr_gray, wptr_rd;
  logic [PW-1:0]     rptr_bin;
  logic [AW-1:0]     rptr_gray, rpair_wr, raddr1;
  logic [1:0]        rstep;
  logic [WORD_W-1:0] rd_lo;
  logic [2*PIX_W-1:0] rd_hi;

  svb_fill #(.DEPTH(DEPTH), .BLW(BLW)) u_fill (
    .clk(wclk), .rst_n(wrst_n), .cls(cls), .cfg_burst(cfg_burst), .cfg_wmark(cfg_wmark),
    .mem_gnt(mem_gnt), .mem_wr_valid(mem_wr_valid), .wptr(wptr_bin),
    .rptr_safe({rpair_wr, 1'b0}), .mem_req(mem_req), .mem_burst(mem_burst),
    .wr_en(wr_en), .busy(busy), .level(wr_level)
  );

  svb_gray_ptr #(.W(PW), .PAIRS(1'b0)) u_wptr (
    .clk(wclk), .rst_n(wrst_n), .step({1'b0, wr_en}), .bin(wptr_bin), .gray(wptr_gray)
  );

  always_ff @(posedge wclk)
    if (wr_en) mem[wptr_bin[AW-1:0]] <= mem_wr_data;

  svb_ptr_sync #(.W(PW)) u_wsync (
    .clk(rclk), .rst_n(rrst_n), .gray_in(wptr_gray), .bin_out(wptr_rd)
  );

  svb_gray_ptr #(.W(PW), .PAIRS(1'b1)) u_rptr (
    .clk(rclk), .rst_n(rrst_n), .step(rstep), .bin(rptr_bin), .gray(rptr_gray)
  );

  svb_ptr_sync #(.W(AW)) u_rsync (
    .clk(wclk), .rst_n(wrst_n), .gray_in(rptr_gray), .bin_out(rpair_wr)
  );

  assign raddr1 = rptr_bin[AW-1:0] + AW'(1);
  assign rd_lo  = mem[rptr_bin[AW-1:0]];
  assign rd_hi  = {mem[raddr1][55:32], mem[raddr1][23:0]};

  svb_drain #(.PW(PW)) u_drain (
    .clk(rclk), .rst_n(rrst_n), .rd_en(rd_en), .wide(wide), .wptr(wptr_rd),
    .rptr(rptr_bin), .lo(rd_lo), .hi(rd_hi), .step(rstep), .pix8(pix8),
    .pix96(pix96), .underflow(underflow)
  );
endmodule

// File: rtl/svb_chk.sv
module svb_chk #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input logic          wclk,
  input logic          wrst_n,
  input logic          rclk,
  input logic          rrst_n,
  input logic          mem_req,
  input logic          mem_gnt,
  input logic          busy,
  input logic          wr_en,
  input logic [PW-1:0] wr_level,
  input logic [PW-1:0] wptr_gray,
  input logic [AW-1:0] rptr_gray,
  input logic          rd_en,
  input logic          underflow,
  input logic [7:0]    pix8,
  input logic [95:0]   pix96
);
  AST_REQ_HOLD: assert property (@(posedge wclk) disable iff (!wrst_n)
    mem_req && !mem_gnt |=> mem_req); // R2
  AST_REQ_DROP: assert property (@(posedge wclk) disable iff (!wrst_n)
    mem_req && mem_gnt |=> !mem_req); // R2
  AST_NO_REQ_IN_BURST: assert property (@(posedge wclk) disable iff (!wrst_n)
    busy |-> !mem_req); // R2
  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!wrst_n)
    wr_en |-> (int'(wr_level) < DEPTH)); // R3
  AST_UNDERFLOW_HOLD: assert property (@(posedge rclk) disable iff (!rrst_n)
    underflow |-> $stable(pix8) && $stable(pix96)); // R6
  AST_UNDERFLOW_CAUSE: assert property (@(posedge rclk) disable iff (!rrst_n)
    underflow |-> $past(rd_en)); // R6
  AST_WPTR_ONE_BIT: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wptr_gray ^ $past(wptr_gray)) <= 1); // R7
  AST_RPTR_ONE_BIT: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(rptr_gray ^ $past(rptr_gray)) <= 1); // R7
endmodule

bind svb_top svb_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_svb_top.sv
`timescale 1ns/1ps
module sim_svb_top;
  localparam int DEPTH = 16;
  localparam int BLW   = 5;
  localparam int PW    = 5;

  logic wclk = 1'b0, rclk = 1'b0;
  logic wrst_n = 1'b0, rrst_n = 1'b0;
  logic [1:0] cls = 2'd0;
  logic [4*BLW-1:0] cfg_burst = '0;
  logic [4*PW-1:0]  cfg_wmark = '0;
  logic mem_req, mem_gnt = 1'b0, mem_wr_valid = 1'b0;
  logic [BLW-1:0] mem_burst;
  logic [63:0] mem_wr_data = '0;
  logic rd_en = 1'b0, wide = 1'b0;
  logic [7:0] pix8;
  logic [95:0] pix96;
  logic underflow;

  int nchk = 0, nfail = 0, seq = 0;
  bit auto_on = 1'b0, resp_busy = 1'b0;
  int auto_len = 4;
  logic [63:0] q[$];

  always #2 wclk = ~wclk;
  always #3 rclk = ~rclk;

  svb_top #(.DEPTH(DEPTH), .BLW(BLW)) u0 (
    .wclk(wclk), .wrst_n(wrst_n), .cls(cls), .cfg_burst(cfg_burst), .cfg_wmark(cfg_wmark),
    .mem_req(mem_req), .mem_burst(mem_burst), .mem_gnt(mem_gnt), .mem_wr_valid(mem_wr_valid),
    .mem_wr_data(mem_wr_data), .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .wide(wide),
    .pix8(pix8), .pix96(pix96), .underflow(underflow)
  );

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mkword(input int k);
    logic [31:0] a, b;
    a = 32'(k) * 32'h9E37_79B1 ^ 32'h5A5A_0F0F;
    b = 32'(k) + 32'h0103_0507 * 32'(k + 1);
    return {a, b};
  endfunction

  function automatic logic [95:0] quad(input logic [63:0] a, input logic [63:0] b);
    return {b[55:32], b[23:0], a[55:32], a[23:0]};
  endfunction

  task automatic set_cfg(input int c, input int b, input int w);
    cfg_burst[c*BLW +: BLW] = BLW'(b);
    cfg_wmark[c*PW +: PW]   = PW'(w);
  endtask

  // acts as the arbiter and memory for one burst of the given length
  task automatic serve(input int len);
    int t;
    resp_busy = 1'b1;
    t = 0;
    while (!mem_req && t < 500) begin @(negedge wclk); t++; end
    chk(mem_req, "R1 request seen", {95'd0, mem_req}, 96'd1);
    chk(mem_burst == BLW'(len), "R1 burst length", 96'(mem_burst), 96'(len));
    repeat (2) begin
      @(negedge wclk);
      chk(mem_req, "R2 request held until grant", {95'd0, mem_req}, 96'd1);
    end
    mem_gnt = 1'b1;
    @(negedge wclk);
    mem_gnt = 1'b0;
    chk(!mem_req, "R2 request dropped after grant", {95'd0, mem_req}, 96'd0);
    for (int i = 0; i < len; i++) begin
      if (i == 2) begin
        mem_wr_valid = 1'b0;
        mem_wr_data  = 64'hBAD0_BAD0_BAD0_BAD0;
        @(negedge wclk);
      end
      mem_wr_valid = 1'b1;
      mem_wr_data  = mkword(seq);
      q.push_back(mkword(seq));
      seq++;
      @(negedge wclk);
    end
    mem_wr_valid = 1'b0;
    resp_busy = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge wclk);
      if (auto_on && mem_req) serve(auto_len);
    end
  end

  task automatic read_narrow_word();
    logic [63:0] w;
    w = q[0];
    for (int b = 0; b < 8; b++) begin
      @(negedge rclk); rd_en = 1'b1; wide = 1'b0;
      @(negedge rclk); rd_en = 1'b0;
      chk(pix8 == w[b*8 +: 8] && !underflow, "R4 R7 narrow byte", {88'd0, pix8}, {88'd0, w[b*8 +: 8]});
    end
    void'(q.pop_front());
  endtask

  task automatic read_wide();
    logic [95:0] e;
    e = quad(q[0], q[1]);
    @(negedge rclk); rd_en = 1'b1; wide = 1'b1;
    @(negedge rclk); rd_en = 1'b0;
    chk(pix96 == e && !underflow, "R5 R7 wide pixels", pix96, e);
    void'(q.pop_front());
    void'(q.pop_front());
  endtask

  task automatic t_reset();
    repeat (5) @(negedge wclk);
    chk(!mem_req, "R8 reset mem_req", {95'd0, mem_req}, 96'd0);
    chk(!underflow, "R8 reset underflow", {95'd0, underflow}, 96'd0);
    chk(pix8 == 8'd0 && pix96 == 96'd0, "R8 reset pixels", pix96 | 96'(pix8), 96'd0);
    wrst_n = 1'b1;
    rrst_n = 1'b1;
  endtask

  task automatic t_first_fill();
    bit seen;
    serve(4);
    seen = 1'b0;
    repeat (20) begin @(negedge wclk); seen |= mem_req; end
    chk(!seen, "R1 no request at or above watermark", {95'd0, seen}, 96'd0);
  endtask

  task automatic t_stray();
    repeat (5) begin
      @(negedge wclk);
      mem_wr_valid = 1'b1;
      mem_wr_data  = 64'hDEAD_BEEF_DEAD_BEEF;
    end
    @(negedge wclk);
    mem_wr_valid = 1'b0;
  endtask

  task automatic t_narrow_stream();
    auto_len = 4;
    auto_on  = 1'b1;
    repeat (20) @(negedge rclk);
    for (int i = 0; i < 6; i++) read_narrow_word();
  endtask

  task automatic t_drain_underflow();
    logic [7:0]  p8;
    logic [95:0] p96;
    auto_on = 1'b0;
    while (resp_busy) @(negedge wclk);
    repeat (60) @(negedge rclk);
    while (q.size() >= 2) read_wide();
    if (q.size() == 1) read_narrow_word();
    p96 = pix96;
    @(negedge rclk); rd_en = 1'b1; wide = 1'b1;
    @(negedge rclk); rd_en = 1'b0;
    chk(underflow, "R6 R3 wide read on empty flags underflow", {95'd0, underflow}, 96'd1);
    chk(pix96 == p96, "R6 pix96 held on underflow", pix96, p96);
    p8 = pix8;
    @(negedge rclk); rd_en = 1'b1; wide = 1'b0;
    @(negedge rclk); rd_en = 1'b0;
    chk(underflow, "R6 R3 narrow read on empty flags underflow", {95'd0, underflow}, 96'd1);
    chk(pix8 == p8, "R6 pix8 held on underflow", {88'd0, pix8}, {88'd0, p8});
    @(negedge rclk);
    chk(!underflow, "R6 underflow lasts one cycle", {95'd0, underflow}, 96'd0);
  endtask

  task automatic t_class_and_room();
    bit seen;
    set_cfg(2, 8, 16);
    cls = 2'd2;
    repeat (2) @(negedge wclk);
    chk(mem_burst == BLW'(4), "R1 burst latched at request", 96'(mem_burst), 96'd4);
    serve(4);
    serve(8);
    seen = 1'b0;
    repeat (30) begin @(negedge wclk); seen |= mem_req; end
    chk(!seen, "R1 no request when burst does not fit", {95'd0, seen}, 96'd0);
    repeat (20) @(negedge rclk);
    for (int i = 0; i < 6; i++) read_wide();
  endtask

  initial begin
    set_cfg(0, 4, 3);
    set_cfg(1, 2, 1);
    set_cfg(3, 6, 2);
    t_reset();
    t_first_fill();
    t_stray();
    t_narrow_stream();
    t_drain_underflow();
    t_class_and_room();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule